// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Detector

This block watches a one-bit serial stream and reports two fixed four-bit patterns. When the four most recently accepted bits are `1001`, output `flag_a` pulses. When they are `1101`, output `flag_b` pulses. Detection overlaps: the bits that end one match can begin the next match of either pattern. Both pulses come from registers and last exactly one clock cycle.

Bits arrive on a valid/ready stream. A bit is consumed on a rising clock edge when `in_valid` is high. The block has no buffer and never stalls, so `in_ready` stays high at all times and the sender never sees back-pressure. When `in_valid` is low the detector's history is frozen.

The state register can use one of three encodings, chosen at build time with the `ENC` parameter. The choices are binary, Gray and one-hot. Every encoding gives cycle-identical outputs, so area and timing can be compared without any change in behaviour. A synchronous reset clears both the history and the flags.

Top module: `seq_pair_detect`

## Requirements
- R1: While `rst` is high at a rising edge, the stream is ignored. After that edge both flags are 0 and all history is gone. A match then needs four bits, all accepted after reset.
- R2: If a bit accepted at edge k makes the last four accepted bits `1001` (oldest bit first), `flag_a` is 1 in the cycle after edge k.
- R3: If a bit accepted at edge k makes the last four accepted bits `1101` (oldest bit first), `flag_b` is 1 in the cycle after edge k.
- R4: Detection overlaps. For example, `1001101` gives `flag_a` after the fourth bit and `flag_b` after the seventh bit. Likewise, `1101001` gives `flag_b` and then `flag_a`.
- R5: A flag is 1 for exactly one cycle per match. It is 0 after any accepted bit that does not complete its pattern.
- R6: A cycle with `in_valid` low consumes no bit and leaves the history unchanged. Both flags are 0 in the cycle that follows it.
- R7: `flag_a` and `flag_b` are never 1 in the same cycle.
- R8: The `ENC` settings `ENC_BINARY`, `ENC_GRAY` and `ENC_ONEHOT` produce identical outputs on every cycle for the same input. The one-hot state holds exactly one set bit. The binary and Gray states only hold codes of the six legal states.
- R9: `in_ready` is 1 in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Stream valid: `in_bit` is consumed at this edge |
| in_bit | input | 1 | Serial data bit |
| in_ready | output | 1 | Stream ready, always 1 |
| flag_a | output | 1 | One-cycle pulse after `1001` is completed |
| flag_b | output | 1 | One-cycle pulse after `1101` is completed |

## Verification
Two functions can land on the same edge: one pattern finishing and the other pattern building its prefix from the same bits. For example, the final `1` of `1001` is also the leading `1` of the next `1101`. The bench provokes this with directed overlapping streams. It also runs an exhaustive sweep of every 12-bit word, sent back-to-back with idle cycles inserted. A shift-register model in the bench judges each output cycle. Every cycle also checks that the two flags are never high together and that the binary, Gray and one-hot builds agree.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  // State encoding styles selectable at build time
  typedef enum logic [1:0] {
    ENC_BINARY = 2'd0,
    ENC_GRAY   = 2'd1,
    ENC_ONEHOT = 2'd2
  } enc_style_e;

  localparam int NUM_STATES = 6;
  localparam int IDX_W      = $clog2(NUM_STATES);

  // Abstract history states: longest suffix of the accepted stream
  // that is a proper prefix of 1001 or 1101.
  typedef enum logic [IDX_W-1:0] {
    H_NONE = 3'd0,   // no useful history
    H_1    = 3'd1,
    H_10   = 3'd2,
    H_100  = 3'd3,
    H_11   = 3'd4,
    H_110  = 3'd5
  } hist_e;

  localparam logic [3:0] PAT_A = 4'b1001;
  localparam logic [3:0] PAT_B = 4'b1101;

  function automatic int code_width(enc_style_e e);
    return (e == ENC_ONEHOT) ? NUM_STATES : IDX_W;
  endfunction

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
(
  input  hist_e cur,
  input  logic  bit_in,
  output hist_e nxt,
  output logic  hit_a,
  output logic  hit_b
);

  // Transition on one accepted bit; completing a pattern leaves "1"
  // as history so overlapping matches are kept.
  always_comb begin
    nxt   = H_NONE;
    hit_a = 1'b0;
    hit_b = 1'b0;
    unique case (cur)
      H_NONE: nxt = bit_in ? H_1 : H_NONE;
      H_1:    nxt = bit_in ? H_11 : H_10;
      H_10:   nxt = bit_in ? H_1 : H_100;
      H_100: begin
        nxt   = bit_in ? H_1 : H_NONE;
        hit_a = bit_in == PAT_A[0];
      end
      H_11:   nxt = bit_in ? H_11 : H_110;
      H_110: begin
        nxt   = bit_in ? H_1 : H_100;
        hit_b = bit_in == PAT_B[0];
      end
      default: nxt = H_NONE;
    endcase
  end

endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
  import seqdet_pkg::*;
#(
  parameter enc_style_e ENC = ENC_BINARY
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  hist_e nxt_idx,
  output hist_e cur_idx
);

  localparam int CW = code_width(ENC);

  logic [CW-1:0] code_q;
  logic [CW-1:0] code_d;
  logic [CW-1:0] code_rst;

  generate
    if (ENC == ENC_ONEHOT) begin : g_onehot
      assign code_rst = CW'(1);
      assign code_d   = CW'(1) << nxt_idx;
      always_comb begin
        cur_idx = H_NONE;
        for (int i = 0; i < NUM_STATES; i++) begin
          if (code_q[i]) cur_idx = hist_e'(IDX_W'(i));
        end
      end
    end else if (ENC == ENC_GRAY) begin : g_gray
      logic [IDX_W-1:0] bin;
      assign code_rst = '0;
      assign code_d   = CW'(nxt_idx ^ (nxt_idx >> 1));
      always_comb begin
        bin[IDX_W-1] = code_q[IDX_W-1];
        for (int i = IDX_W - 2; i >= 0; i--) begin
          bin[i] = bin[i+1] ^ code_q[i];
        end
      end
      assign cur_idx = hist_e'(bin);
    end else begin : g_binary
      assign code_rst = '0;
      assign code_d   = CW'(nxt_idx);
      assign cur_idx  = hist_e'(code_q[IDX_W-1:0]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       code_q <= code_rst;
    else if (load) code_q <= code_d;
  end

  // R6: without a valid bit the state register holds
  a_r6_state_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(code_q));

  // R8: the register only ever holds a legal code
  generate
    if (ENC == ENC_ONEHOT) begin : g_chk_oh
      a_r8_onehot_legal: assert property (@(posedge clk) disable iff (rst)
        $countones(code_q) == 1);
    end else begin : g_chk_bin
      a_r8_code_legal: assert property (@(posedge clk) disable iff (rst)
        cur_idx <= H_110);
    end
  endgenerate

endmodule

// File: rtl/seqdet_flags.sv
module seqdet_flags (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic hit_a,
  input  logic hit_b,
  output logic flag_a,
  output logic flag_b
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_a <= 1'b0;
      flag_b <= 1'b0;
    end else begin
      flag_a <= take & hit_a;
      flag_b <= take & hit_b;
    end
  end

  // R7: the two patterns differ in their second bit, so never both
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(flag_a && flag_b));

  // R5: a match pulse is a single cycle
  a_r5_pulse_a: assert property (@(posedge clk) disable iff (rst)
    flag_a |=> !flag_a);
  a_r5_pulse_b: assert property (@(posedge clk) disable iff (rst)
    flag_b |=> !flag_b);

  // R6: an idle input cycle yields no flag
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !take |=> !flag_a && !flag_b);

endmodule

// File: rtl/seq_pair_detect.sv
module seq_pair_detect
  import seqdet_pkg::*;
#(
  parameter enc_style_e ENC = ENC_BINARY
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic flag_a,
  output logic flag_b
);

  hist_e cur_st;
  hist_e nxt_st;
  logic  hit_a;
  logic  hit_b;

  // R9: no buffering, never back-pressures
  assign in_ready = 1'b1;

  seqdet_next u_next (
    .cur    (cur_st),
    .bit_in (in_bit),
    .nxt    (nxt_st),
    .hit_a  (hit_a),
    .hit_b  (hit_b)
  );

  seqdet_state_reg #(.ENC(ENC)) u_state (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .nxt_idx (nxt_st),
    .cur_idx (cur_st)
  );

  seqdet_flags u_flags (
    .clk    (clk),
    .rst    (rst),
    .take   (in_valid),
    .hit_a  (hit_a),
    .hit_b  (hit_b),
    .flag_a (flag_a),
    .flag_b (flag_b)
  );

  // R2/R3: a flag follows only an accepted bit
  a_r2_flag_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (flag_a || flag_b) |-> $past(in_valid));

endmodule

// File: tb/sim_seq_pair_detect.sv
module sim_seq_pair_detect;
  import seqdet_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic rdy0, rdy1, rdy2;
  logic fa0, fb0, fa1, fb1, fa2, fb2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] hist = 4'b0;
  int acc = 0;

  always #10 clk = ~clk;

  seq_pair_detect u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
                      .in_ready(rdy0), .flag_a(fa0), .flag_b(fb0));
  seq_pair_detect #(.ENC(ENC_GRAY)) u1 (.clk(clk), .rst(rst), .in_valid(in_valid),
                      .in_bit(in_bit), .in_ready(rdy1), .flag_a(fa1), .flag_b(fb1));
  seq_pair_detect #(.ENC(ENC_ONEHOT)) u2 (.clk(clk), .rst(rst), .in_valid(in_valid),
                      .in_bit(in_bit), .in_ready(rdy2), .flag_a(fa2), .flag_b(fb2));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic b, input string tag);
    logic ea, eb;
    string ta, tb;
    @(negedge clk);
    rst = 1'b0; in_valid = v; in_bit = b;
    if (v) begin
      hist = {hist[2:0], b};
      if (acc < 4) acc++;
    end
    ea = v && acc >= 4 && hist == 4'b1001;
    eb = v && acc >= 4 && hist == 4'b1101;
    ta = (tag != "") ? tag : (ea ? "R2" : (v ? "R5" : "R6"));
    tb = (tag != "") ? tag : (eb ? "R3" : (v ? "R5" : "R6"));
    @(posedge clk); #1;
    check(fa0 === ea, ta, "flag_a", int'(fa0), int'(ea));
    check(fb0 === eb, tb, "flag_b", int'(fb0), int'(eb));
    check(!(fa0 && fb0), "R7", "both flags", int'({fa0, fb0}), 0);
    check({fa1, fb1, fa2, fb2} === {fa0, fb0, fa0, fb0}, "R8", "encodings differ",
          int'({fa1, fb1, fa2, fb2}), int'({fa0, fb0, fa0, fb0}));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check({fa0, fb0, fa1, fb1, fa2, fb2} == 6'b0, "R1", "flags in reset",
          int'({fa0, fb0, fa1, fb1, fa2, fb2}), 0);
    check({rdy0, rdy1, rdy2} == 3'b111, "R9", "in_ready", int'({rdy0, rdy1, rdy2}), 7);
    hist = 4'b0;
    acc = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: history before reset is discarded
    step(1, 1, "R1"); step(1, 0, "R1"); step(1, 0, "R1");
    do_reset();
    step(1, 0, "R1"); step(1, 0, "R1"); step(1, 1, "R1");
    // R2 then R4 overlap: 1001 101
    do_reset();
    step(1, 1, ""); step(1, 0, ""); step(1, 0, ""); step(1, 1, "R2");
    step(1, 1, "R4"); step(1, 0, "R4"); step(1, 1, "R4");
    // R3 then R4 overlap: 1101 001, with idle cycles in between (R6)
    do_reset();
    step(1, 1, ""); step(1, 1, ""); step(1, 0, ""); step(1, 1, "R3");
    step(0, 0, "R6"); step(1, 0, "R4"); step(0, 1, "R6"); step(1, 0, "R4");
    step(1, 1, "R4");
    // R9 outside reset
    check({rdy0, rdy1, rdy2} == 3'b111, "R9", "in_ready", int'({rdy0, rdy1, rdy2}), 7);
    // Exhaustive sweep of all 12-bit words with idle cycles inserted
    for (int n = 0; n < 4096; n++) begin
      if ((n % 256) == 0) do_reset();
      for (int i = 11; i >= 0; i--) begin
        if (((n * 7 + i) % 5) == 0) step(0, ~n[i], "");
        step(1, n[i], "");
      end
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule